// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Add/Subtract Core

This core adds or subtracts two IEEE-754 single-precision numbers in a fixed nine-stage pipeline. Add and subtract use the same datapath. For subtraction, the sign of the second operand is inverted on entry.

Each operand has its own valid strobe, so a controller can fetch the two operands from memory in separate cycles. An operand that arrives first is held inside the core until its partner arrives. In the cycle the pair completes, the pair enters the pipeline and the add/subtract select is sampled. Exactly nine cycles later the result appears, marked by a one-cycle result strobe. The controller never sequences the internal stages. It only raises the operand strobes and collects results on the result strobe.

Results are rounded to nearest, with ties going to even. Subnormal operands count as zero, and results below the normal range become a signed zero. Infinities and NaNs follow simple fixed rules.

Top module: `fp_addsub_core`

## Requirements
- R1: A pair that completes in cycle t makes `res_valid` high for exactly one cycle, in cycle t+9, with that pair's result on `res_data`. No result strobe appears without a pair.
- R2: Operands may arrive in the same cycle or in either order, with any number of idle cycles between them. An operand that arrives alone is held until its partner's strobe.
- R3: If a second strobe on the same operand port arrives before the partner, the newer value replaces the held one.
- R4: A new pair can complete in every cycle. Results come out in the order the pairs completed.
- R5: `op_sub` is sampled only in the cycle the pair completes: 0 gives a+b and 1 gives a-b. Its value in the cycle an earlier lone operand arrived has no effect.
- R6: A finite normal result is the exact sum rounded to 24 significant bits, with ties going to the even significand.
- R7: An exact zero sum is +0, except that the sum of two negative zeros is -0 (0x80000000).
- R8: If the rounded magnitude reaches 2^128, the result is infinity (exponent field 0xFF, fraction 0) with the sign of the exact result.
- R9: The result is the quiet NaN 0x7FC00000 when either operand is a NaN (exponent field 0xFF, fraction non-zero), or when infinities of opposite effective sign are added.
- R10: One infinite operand combined with a finite operand gives that infinity, with its effective sign. Two infinities of the same effective sign give that infinity.
- R11: Operands with exponent field 0 count as zero (keeping their sign). A rounded result whose biased exponent would be 0 or less becomes zero with the sign of the exact result.
- R12: While reset is applied and after it is released, `res_valid` is low. Reset discards any held operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_valid | input | 1 | Strobe: `a_data` holds a valid first operand |
| a_data | input | 32 | First operand, single precision |
| b_valid | input | 1 | Strobe: `b_data` holds a valid second operand |
| b_data | input | 32 | Second operand, single precision |
| op_sub | input | 1 | 0 selects add, 1 selects subtract; sampled when the pair completes |
| res_valid | output | 1 | One-cycle strobe marking a result |
| res_data | output | 32 | Result, single precision |

## Verification
A wrong operand-holding state shows within nine cycles. Either a result strobe appears that no pair explains, or a result is computed from a stale or missing operand. The bench checks every strobe against a schedule derived from pair completion cycles. An error in the alignment, normalization or rounding stages shows only as a wrong `res_data` word nine cycles after the pair. The bench therefore compares every result bit for bit with an exact reference model. The operand sets concentrate on ties, cancellation, overflow, underflow and special values.

// File: rtl/fp_addsub_pkg.sv
package fp_addsub_pkg;
  localparam int FP_W       = 32;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = 23;
  localparam int SIG_W      = MAN_W + 1;
  localparam int GRS_W      = 3;
  localparam int EXT_W      = SIG_W + GRS_W;
  localparam int SUM_W      = EXT_W + 1;
  localparam int EXPI_W     = EXP_W + 2;
  localparam int LZ_W       = $clog2(SUM_W + 1);
  localparam int NUM_STAGES = 9;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [FP_W-1:0]  QNAN    = 32'h7FC0_0000;

  typedef struct packed {
    logic              spec;
    logic [FP_W-1:0]   sval;
    logic              sa;
    logic              sb;
    logic [EXPI_W-1:0] ea;
    logic [EXPI_W-1:0] eb;
    logic [SIG_W-1:0]  ma;
    logic [SIG_W-1:0]  mb;
    logic              sign;
    logic              sub;
    logic              zsign;
    logic              zero;
    logic [EXPI_W-1:0] exp;
    logic [EXPI_W-1:0] shamt;
    logic [EXT_W-1:0]  hi_m;
    logic [EXT_W-1:0]  lo_m;
    logic [SUM_W-1:0]  sum;
    logic [LZ_W-1:0]   lz;
    logic [SIG_W:0]    rm;
  } pipe_t;

  // Unpack both operands, flush subnormals, resolve special operands.
  function automatic pipe_t fp_load(input logic [FP_W-1:0] a, input logic [FP_W-1:0] b,
                                    input logic sub);
    pipe_t p;
    logic [EXP_W-1:0] ea, eb;
    logic [MAN_W-1:0] fa, fb;
    logic sb, a_nan, b_nan, a_inf, b_inf;
    p     = '0;
    ea    = a[FP_W-2 -: EXP_W];
    eb    = b[FP_W-2 -: EXP_W];
    fa    = a[MAN_W-1:0];
    fb    = b[MAN_W-1:0];
    sb    = b[FP_W-1] ^ sub;
    a_nan = (ea == EXP_MAX) && (fa != '0);
    b_nan = (eb == EXP_MAX) && (fb != '0);
    a_inf = (ea == EXP_MAX) && (fa == '0);
    b_inf = (eb == EXP_MAX) && (fb == '0);
    p.sa    = a[FP_W-1];
    p.sb    = sb;
    p.ea    = EXPI_W'(ea);
    p.eb    = EXPI_W'(eb);
    p.ma    = (ea == '0) ? '0 : {1'b1, fa};
    p.mb    = (eb == '0) ? '0 : {1'b1, fb};
    p.zsign = a[FP_W-1] & sb;
    if (a_nan || b_nan || (a_inf && b_inf && (a[FP_W-1] != sb))) begin
      p.spec = 1'b1;
      p.sval = QNAN;
    end else if (a_inf) begin
      p.spec = 1'b1;
      p.sval = {a[FP_W-1], EXP_MAX, {MAN_W{1'b0}}};
    end else if (b_inf) begin
      p.spec = 1'b1;
      p.sval = {sb, EXP_MAX, {MAN_W{1'b0}}};
    end
    return p;
  endfunction

  // Work done by pipeline stage k (stage 1 only registers the unpacked pair).
  function automatic pipe_t fp_step(input int k, input pipe_t p);
    pipe_t n;
    logic a_ge, up;
    logic [EXT_W-1:0] mask;
    n    = p;
    a_ge = 1'b0;
    up   = 1'b0;
    mask = '0;
    case (k)
      2: begin  // order by magnitude
        a_ge    = {p.ea, p.ma} >= {p.eb, p.mb};
        n.sign  = a_ge ? p.sa : p.sb;
        n.sub   = p.sa ^ p.sb;
        n.exp   = a_ge ? p.ea : p.eb;
        n.shamt = a_ge ? (p.ea - p.eb) : (p.eb - p.ea);
        n.hi_m  = {(a_ge ? p.ma : p.mb), {GRS_W{1'b0}}};
        n.lo_m  = {(a_ge ? p.mb : p.ma), {GRS_W{1'b0}}};
      end
      3: begin  // align smaller operand, keep sticky
        if (p.shamt >= EXPI_W'(EXT_W)) begin
          n.lo_m = EXT_W'(|p.lo_m);
        end else begin
          mask   = (EXT_W'(1) << p.shamt) - EXT_W'(1);
          n.lo_m = (p.lo_m >> p.shamt) | EXT_W'(|(p.lo_m & mask));
        end
      end
      4: n.sum = p.sub ? ({1'b0, p.hi_m} - {1'b0, p.lo_m})
                       : ({1'b0, p.hi_m} + {1'b0, p.lo_m});
      5: begin  // leading-zero count from the carry bit down
        n.lz = LZ_W'(SUM_W);
        for (int i = 0; i < SUM_W; i++) begin
          if (p.sum[i]) n.lz = LZ_W'(SUM_W - 1 - i);
        end
      end
      6: begin  // normalize so the hidden bit sits at EXT_W-1
        n.zero = (p.sum == '0);
        if (p.lz == '0) begin
          n.hi_m = {p.sum[SUM_W-1:2], |p.sum[1:0]};
          n.exp  = p.exp + EXPI_W'(1);
        end else begin
          n.hi_m = p.sum[EXT_W-1:0] << (p.lz - LZ_W'(1));
          n.exp  = p.exp - EXPI_W'(p.lz) + EXPI_W'(1);
        end
      end
      7: begin  // round to nearest, ties to even
        up   = p.hi_m[GRS_W-1] & (p.hi_m[GRS_W-2] | p.hi_m[0] | p.hi_m[GRS_W]);
        n.rm = {1'b0, p.hi_m[EXT_W-1:GRS_W]} + (SIG_W + 1)'(up);
      end
      8: begin  // carry out of rounding, range limits
        if (p.rm[SIG_W]) begin
          n.rm  = p.rm >> 1;
          n.exp = p.exp + EXPI_W'(1);
        end
        if (!p.spec) begin
          if (p.zero) begin
            n.spec = 1'b1;
            n.sval = {p.zsign, {(FP_W-1){1'b0}}};
          end else if (int'($signed(n.exp)) >= int'(EXP_MAX)) begin
            n.spec = 1'b1;
            n.sval = {p.sign, EXP_MAX, {MAN_W{1'b0}}};
          end else if (int'($signed(n.exp)) <= 0) begin
            n.spec = 1'b1;
            n.sval = {p.sign, {(FP_W-1){1'b0}}};
          end
        end
      end
      default: n = p;
    endcase
    return n;
  endfunction

  function automatic logic [FP_W-1:0] fp_pack(input pipe_t p);
    return p.spec ? p.sval : {p.sign, p.exp[EXP_W-1:0], p.rm[MAN_W-1:0]};
  endfunction
endpackage

// File: rtl/fp_pair_latch.sv
module fp_pair_latch
  import fp_addsub_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_valid,
  input  logic [FP_W-1:0] a_data,
  input  logic            b_valid,
  input  logic [FP_W-1:0] b_data,
  output logic            fire,
  output logic [FP_W-1:0] a_word,
  output logic [FP_W-1:0] b_word
);
  logic a_have, b_have, a_have_n, b_have_n;
  logic [FP_W-1:0] a_hold, b_hold;

  always_comb begin
    fire     = (a_have | a_valid) & (b_have | b_valid);
    a_have_n = (a_have | a_valid) & ~fire;
    b_have_n = (b_have | b_valid) & ~fire;
    a_word   = a_valid ? a_data : a_hold;
    b_word   = b_valid ? b_data : b_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_have <= 1'b0;
      b_have <= 1'b0;
    end else begin
      a_have <= a_have_n;
      b_have <= b_have_n;
    end
  end

  always_ff @(posedge clk) begin
    if (a_valid) a_hold <= a_data;
    if (b_valid) b_hold <= b_data;
  end

  AST_LONE_A_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !b_valid && !b_have |=> a_have);  // R2
  AST_LONE_B_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !a_valid && !a_have |=> b_have);  // R2
  AST_PAIR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !a_have && !b_have);  // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    a_have && !a_valid |=> $stable(a_hold));  // R3
endmodule

// File: rtl/fp_pipe_stage.sv
module fp_pipe_stage
  import fp_addsub_pkg::*;
#(
  parameter int STAGE = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  pipe_t in_data,
  output logic  out_valid,
  output pipe_t out_data
);
  logic  valid_n;
  pipe_t data_n;

  always_comb begin
    valid_n = in_valid;
    data_n  = fp_step(STAGE, in_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= data_n;
  end

  AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R1
  AST_STAGE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R1
endmodule

// File: rtl/fp_addsub_core.sv
module fp_addsub_core
  import fp_addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_valid,
  input  logic [31:0] a_data,
  input  logic        b_valid,
  input  logic [31:0] b_data,
  input  logic        op_sub,
  output logic        res_valid,
  output logic [31:0] res_data
);
  localparam int LAST = NUM_STAGES - 1;

  logic [1:0]      rst_sync;
  logic            rst_s;
  logic            fire;
  logic [FP_W-1:0] a_word, b_word;
  logic            vq [0:LAST];
  pipe_t           st [0:LAST];
  logic            res_valid_n;
  logic [FP_W-1:0] res_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  fp_pair_latch u_pair (
    .clk    (clk),
    .rst_n  (rst_s),
    .a_valid(a_valid),
    .a_data (a_data),
    .b_valid(b_valid),
    .b_data (b_data),
    .fire   (fire),
    .a_word (a_word),
    .b_word (b_word)
  );

  assign vq[0] = fire;
  assign st[0] = fp_load(a_word, b_word, op_sub);

  for (genvar k = 1; k <= LAST; k++) begin : g_stage
    fp_pipe_stage #(.STAGE(k)) u_stage (
      .clk      (clk),
      .rst_n    (rst_s),
      .in_valid (vq[k-1]),
      .in_data  (st[k-1]),
      .out_valid(vq[k]),
      .out_data (st[k])
    );
  end

  // final stage: pack
  always_comb begin
    res_valid_n = vq[LAST];
    res_n       = fp_pack(st[LAST]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) res_valid <= 1'b0;
    else        res_valid <= res_valid_n;
  end

  always_ff @(posedge clk) begin
    if (vq[LAST]) res_data <= res_n;
  end

  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    res_valid && (res_data[30:23] == 8'hFF) && (res_data[22:0] != '0)
      |-> res_data == QNAN);  // R9
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_s)
    res_valid && (res_data[30:23] == 8'h00) |-> res_data[22:0] == '0);  // R11
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s |=> !res_valid || rst_s);  // R12
endmodule

// File: tb/fp_addsub_core_bench.sv
`timescale 1ns/1ps
module fp_addsub_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_valid, b_valid, op_sub;
  logic [31:0] a_data, b_data;
  logic        res_valid;
  logic [31:0] res_data;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  logic [31:0] xs_state = 32'h1234_5678;
  logic [31:0] exp_q[$];
  longint      due_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  fp_addsub_core u_fp_addsub_core (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data), .op_sub(op_sub),
    .res_valid(res_valid), .res_data(res_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model: exact double arithmetic ----------------
  function automatic real f2r(input logic [31:0] x);
    if (x[30:23] == 8'h00) return $bitstoreal({x[31], 63'b0});  // R11 flush
    return $bitstoreal({x[31], 11'(x[30:23]) + 11'd896, x[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] bits;
    logic [23:0] keep;
    logic [28:0] rem;
    logic [24:0] m;
    logic        up;
    int          ef;
    bits = $realtobits(r);
    if (bits[62:52] == 11'd0) return {bits[63], 31'b0};
    keep = {1'b1, bits[51:29]};
    rem  = bits[28:0];
    up   = (rem > 29'h1000_0000) || ((rem == 29'h1000_0000) && keep[0]);  // R6
    m    = {1'b0, keep} + 25'(up);
    ef   = int'(bits[62:52]) - 896;
    if (m[24]) begin
      m  = m >> 1;
      ef = ef + 1;
    end
    if (ef >= 255) return {bits[63], 8'hFF, 23'b0};  // R8
    if (ef <= 0) return {bits[63], 31'b0};           // R11
    return {bits[63], ef[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                         input logic sub);
    logic [31:0] bb;
    logic a_nan, b_nan, a_inf, b_inf;
    bb    = {b[31] ^ sub, b[30:0]};
    a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    b_nan = (bb[30:23] == 8'hFF) && (bb[22:0] != 0);
    a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    b_inf = (bb[30:23] == 8'hFF) && (bb[22:0] == 0);
    if (a_nan || b_nan) return 32'h7FC0_0000;                        // R9
    if (a_inf && b_inf) return (a[31] != bb[31]) ? 32'h7FC0_0000 : a; // R9 R10
    if (a_inf) return a;                                              // R10
    if (b_inf) return bb;
    return r2f(f2r(a) + f2r(bb));
  endfunction

  function automatic logic [31:0] xs_next(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      checks++;
      if (!res_valid || res_data !== exp_q[0]) begin
        fails++;
        $display("FAIL %s: valid=%b data=%h expected valid=1 data=%h", tag_q[0],
                 res_valid, res_data, exp_q[0]);
      end
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
      void'(tag_q.pop_front());
    end else if (res_valid === 1'b1) begin
      checks++;
      fails++;
      $display("FAIL R1: unexpected result strobe data=%h, expected no strobe", res_data);
    end
  end

  // ---------------- drivers ----------------
  task automatic expect_pair(input logic [31:0] a, input logic [31:0] b, input logic sub,
                             input string tag);
    exp_q.push_back(ref_op(a, b, sub));
    due_q.push_back(cyc + 9);  // R1: nine cycles after completion
    tag_q.push_back(tag);
  endtask

  task automatic drive_pair(input logic [31:0] a, input logic [31:0] b, input logic sub,
                            input string tag);
    @(negedge clk);
    a_valid = 1'b1; a_data = a;
    b_valid = 1'b1; b_data = b;
    op_sub  = sub;
    expect_pair(a, b, sub, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    a_valid = 1'b0;
    b_valid = 1'b0;
    a_data  = 32'hDEAD_BEEF;
    b_data  = 32'hDEAD_BEEF;
  endtask

  // first operand alone (op_sub opposite), gap cycles, then partner with real op_sub
  task automatic drive_split(input logic [31:0] a, input logic [31:0] b, input logic sub,
                             input int gap, input logic a_first, input string tag);
    @(negedge clk);
    if (a_first) begin a_valid = 1'b1; a_data = a; end
    else         begin b_valid = 1'b1; b_data = b; end
    op_sub = ~sub;  // R5: ignored here
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      a_valid = 1'b0;
      b_valid = 1'b0;
      a_data  = 32'hDEAD_BEEF;
      b_data  = 32'hDEAD_BEEF;
      op_sub  = ~sub;
    end
    @(negedge clk);
    if (a_first) begin b_valid = 1'b1; b_data = b; end
    else         begin a_valid = 1'b1; a_data = a; end
    op_sub = sub;
    expect_pair(a, b, sub, tag);
    idle();
  endtask

  task automatic drain();
    while (due_q.size() > 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_quiet(input string tag);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: res_valid=%b expected 0", tag, res_valid);
    end
  endtask

  logic [31:0] vals [16];

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    vals = '{32'h3F80_0000, 32'hBF80_0000, 32'h3F80_0001, 32'h4B80_0000,
             32'h3EAA_AAAB, 32'hC049_0FDB, 32'h0080_0000, 32'h8080_0001,
             32'h0040_0000, 32'h0000_0000, 32'h8000_0000, 32'h7F7F_FFFF,
             32'hFF7F_FFFF, 32'h7F80_0000, 32'hFF80_0000, 32'h7FA0_0001};
    rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; op_sub = 1'b0;
    a_data = '0; b_data = '0;
    repeat (3) @(negedge clk);
    check_quiet("R12");  // reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R12");

    // directed corner cases
    drive_pair(32'h3FC0_0000, 32'h4040_0000, 1'b0, "R1");  // 1.5 + 3
    drive_pair(32'h4B80_0000, 32'h3F80_0000, 1'b0, "R6");  // tie to even, stays 2^24
    drive_pair(32'h4B80_0000, 32'h4040_0000, 1'b0, "R6");  // tie rounds up to even
    drive_pair(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R7");  // x - x = +0
    drive_pair(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");  // -0 + -0 = -0
    drive_pair(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, "R8");  // overflow +inf
    drive_pair(32'hFF7F_FFFF, 32'h7F7F_FFFF, 1'b1, "R8");  // overflow -inf
    drive_pair(32'h7F80_0000, 32'h7F80_0000, 1'b1, "R9");  // inf - inf
    drive_pair(32'h7FA0_0001, 32'h3F80_0000, 1'b0, "R9");  // NaN operand
    drive_pair(32'hFF80_0000, 32'h3F80_0000, 1'b0, "R10"); // -inf + 1
    drive_pair(32'h3F80_0000, 32'hFF80_0000, 1'b1, "R10"); // 1 - (-inf)
    drive_pair(32'h0040_0000, 32'h3F80_0000, 1'b0, "R11"); // subnormal operand
    drive_pair(32'h0080_0001, 32'h0080_0000, 1'b1, "R11"); // underflow flush
    drive_pair(32'h8080_0000, 32'h0000_0001, 1'b0, "R11");
    idle();
    drain();

    // R4: full sweep, one pair per cycle
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          drive_pair(vals[i], vals[j], op[0], "R4");
    idle();
    drain();

    // R2 and R5: split arrivals in both orders with varying gaps
    for (int t = 0; t < 160; t++) begin
      logic [31:0] ra, rb;
      xs_state = xs_next(xs_state); ra = xs_state;
      xs_state = xs_next(xs_state);
      rb = xs_state[3] ? xs_state
                       : {xs_state[31], ra[30:23] ^ {5'b0, xs_state[26:24]}, xs_state[22:0]};
      drive_split(ra, rb, xs_state[4], 1 + (t % 3), t[0], t[1] ? "R5" : "R2");
    end
    drain();

    // R3: a newer strobe on the same port replaces the held operand
    for (int t = 0; t < 24; t++) begin
      logic [31:0] junk, ra, rb;
      xs_state = xs_next(xs_state); junk = xs_state;
      xs_state = xs_next(xs_state); ra = xs_state;
      xs_state = xs_next(xs_state); rb = {xs_state[31], ra[30:23], xs_state[22:0]};
      @(negedge clk);
      if (t[0]) begin b_valid = 1'b1; b_data = junk; end
      else      begin a_valid = 1'b1; a_data = junk; end
      idle();
      drive_split(ra, rb, xs_state[5], 1, ~t[0], "R3");
    end
    drain();

    // R4 and R6: random stream, one pair per cycle, close exponents
    for (int t = 0; t < 1500; t++) begin
      logic [31:0] ra, rb;
      xs_state = xs_next(xs_state); ra = xs_state;
      xs_state = xs_next(xs_state);
      rb = xs_state[3] ? xs_state
                       : {xs_state[31], ra[30:23] ^ {5'b0, xs_state[26:24]}, xs_state[22:0]};
      drive_pair(ra, rb, xs_state[7], t[0] ? "R6" : "R4");
    end
    idle();
    drain();

    // R12: reset discards a held operand
    @(negedge clk);
    a_valid = 1'b1; a_data = 32'h4120_0000;
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_quiet("R12");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive_split(32'h3F80_0000, 32'h4000_0000, 1'b0, 2, 1'b0, "R12");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule